// File: doc/BRIEF.md
# 64-bit SECDED Encoder and Error Locator

This block protects a 64-bit data word with eight check bits built from a fixed, irregular parity matrix. On the write side, the check byte it produces is stored with the data. On the read side, the stored data and the stored check byte are presented together with a valid strobe. The block then recomputes the check byte, forms the syndrome and works out which single bit, if any, is wrong.

All results are registered and appear one clock after the strobe, qualified by an output valid. The results are the recomputed check byte, the syndrome, a faulty data bit index or faulty check bit index with its flag, the corrected data and check byte, and an uncorrectable flag. The locator searches the data-bit columns first, in ascending bit order. It treats the syndrome as a check-bit error only when no data column matches.

Top module: `secded64_codec`

## Requirements
- R1: `enc_check[k]` is the XOR of the data bits selected by a 64-bit mask, registered from `in_data`. The upper 32 mask bits cover data bits 63:32 and the lower 32 cover bits 31:0. The masks for k = 0..7 are 0xf00fe11e_c33c0ff7, 0x00ff00ff_00fff0ff, 0x0f0f0f0f_0f0fff00, 0x11113333_7777000f, 0x22224444_8888222f, 0x44448888_ffff4441, 0x8888ffff_11118882 and 0xffff1111_22221114.
- R2: `syndrome` equals the recomputed check byte XOR `in_check`.
- R3: A zero syndrome raises none of `data_err_valid`, `check_err_valid` and `uncorrectable`. `corr_data` and `corr_check` then equal the captured inputs.
- R4: The column of data bit n is the 8-bit value whose bit k is bit n of mask k. If a nonzero syndrome equals the column of one or more data bits, the lowest such n is reported: `data_err_valid` = 1, `data_err_idx` = n, `corr_data` = captured data with bit n inverted, and `corr_check` = captured check byte.
- R5: If a nonzero syndrome matches no data column and has exactly one bit k set, then `check_err_valid` = 1 and `check_err_idx` = k. `corr_check` is then the captured check byte with bit k inverted, and `corr_data` is unchanged.
- R6: If a nonzero syndrome matches no data column and has two or more bits set, then `uncorrectable` = 1 and neither output word is altered.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the results belong to that input.
- R8: While `in_valid` is low, every result output keeps its last value.
- R9: At most one of `data_err_valid`, `check_err_valid` and `uncorrectable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 64 | Captured data word |
| in_check | input | 8 | Captured check byte |
| out_valid | output | 1 | Results valid |
| enc_check | output | 8 | Check byte recomputed from `in_data` |
| syndrome | output | 8 | Recomputed XOR received check byte |
| data_err_valid | output | 1 | A data bit was located |
| data_err_idx | output | 6 | Index of the faulty data bit |
| check_err_valid | output | 1 | A check bit was located |
| check_err_idx | output | 3 | Index of the faulty check bit |
| uncorrectable | output | 1 | Nonzero syndrome with no single-bit explanation |
| corr_data | output | 64 | Corrected data word |
| corr_check | output | 8 | Corrected check byte |

## Verification
On every cycle the assertions check the following:
- the output-valid timing and the hold behaviour;
- that the three outcome flags are mutually exclusive;
- that a located data error changes exactly one data bit and leaves the check byte alone;
- that a check-bit result rests on a single-bit syndrome and an uncorrectable one on a multi-bit syndrome;
- that a clean syndrome passes the word through.

Only the bench scenarios can show that the matrix, the ascending column search and the exact indices match the arithmetic model. They sweep all 256 syndromes over two data words and flip each of the 64 data bits and 8 check bits, which exposes any mask or priority error.

// File: rtl/secded64_pkg.sv
package secded64_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int DIDX_W = $clog2(DATA_W);
  localparam int CIDX_W = $clog2(CHK_W);

  // Parity mask for check bit k: upper half covers data 63:32, lower half 31:0.
  function automatic logic [DATA_W-1:0] chk_mask(input int k);
    case (k)
      0: return {32'hf00fe11e, 32'hc33c0ff7};
      1: return {32'h00ff00ff, 32'h00fff0ff};
      2: return {32'h0f0f0f0f, 32'h0f0fff00};
      3: return {32'h11113333, 32'h7777000f};
      4: return {32'h22224444, 32'h8888222f};
      5: return {32'h44448888, 32'hffff4441};
      6: return {32'h8888ffff, 32'h11118882};
      7: return {32'hffff1111, 32'h22221114};
      default: return '0;
    endcase
  endfunction

  // Syndrome produced when data bit n alone is inverted.
  function automatic logic [CHK_W-1:0] data_column(input int n);
    logic [CHK_W-1:0]  col;
    logic [DATA_W-1:0] m;
    col = '0;
    for (int k = 0; k < CHK_W; k++) begin
      m      = chk_mask(k);
      col[k] = m[n];
    end
    return col;
  endfunction

  typedef struct packed {
    logic              data_hit;
    logic [DIDX_W-1:0] data_idx;
    logic              chk_hit;
    logic [CIDX_W-1:0] chk_idx;
    logic              uncorr;
  } locate_t;
endpackage

// File: rtl/secded64_parity.sv
module secded64_parity
  import secded64_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [DATA_W-1:0] MASK = chk_mask(k);
    assign check[k] = ^(data & MASK);
  end
endmodule

// File: rtl/secded64_locator.sv
module secded64_locator
  import secded64_pkg::*;
(
  input  logic [CHK_W-1:0] syn,
  output locate_t          res
);
  logic [DATA_W-1:0] hit;

  for (genvar n = 0; n < DATA_W; n++) begin : g_col
    localparam logic [CHK_W-1:0] COL = data_column(n);
    assign hit[n] = (syn == COL) && (|syn);
  end

  always_comb begin
    res = '0;
    // Descending scan so the lowest matching column wins.
    for (int n = DATA_W - 1; n >= 0; n--) begin
      if (hit[n]) begin
        res.data_hit = 1'b1;
        res.data_idx = DIDX_W'(n);
      end
    end
    if (!res.data_hit && (|syn)) begin
      if ($countones(syn) == 1) begin
        res.chk_hit = 1'b1;
        for (int k = CHK_W - 1; k >= 0; k--) begin
          if (syn[k]) res.chk_idx = CIDX_W'(k);
        end
      end else begin
        res.uncorr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/secded64_codec.sv
module secded64_codec
  import secded64_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [63:0]       in_data,
  input  logic [7:0]        in_check,
  output logic              out_valid,
  output logic [7:0]        enc_check,
  output logic [7:0]        syndrome,
  output logic              data_err_valid,
  output logic [5:0]        data_err_idx,
  output logic              check_err_valid,
  output logic [2:0]        check_err_idx,
  output logic              uncorrectable,
  output logic [63:0]       corr_data,
  output logic [7:0]        corr_check
);
  localparam logic [DATA_W-1:0] DONE = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [CHK_W-1:0]  CONE = {{(CHK_W-1){1'b0}}, 1'b1};

  logic [CHK_W-1:0]  calc_chk;
  logic [CHK_W-1:0]  syn_c;
  locate_t           loc;
  logic [DATA_W-1:0] fix_d;
  logic [CHK_W-1:0]  fix_c;

  secded64_parity u_parity (
    .data  (in_data),
    .check (calc_chk)
  );

  assign syn_c = calc_chk ^ in_check;

  secded64_locator u_locator (
    .syn (syn_c),
    .res (loc)
  );

  always_comb begin
    fix_d = in_data;
    fix_c = in_check;
    if (loc.data_hit) fix_d = in_data ^ (DONE << loc.data_idx);
    if (loc.chk_hit)  fix_c = in_check ^ (CONE << loc.chk_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      enc_check       <= '0;
      syndrome        <= '0;
      data_err_valid  <= 1'b0;
      data_err_idx    <= '0;
      check_err_valid <= 1'b0;
      check_err_idx   <= '0;
      uncorrectable   <= 1'b0;
      corr_data       <= '0;
      corr_check      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        enc_check       <= calc_chk;
        syndrome        <= syn_c;
        data_err_valid  <= loc.data_hit;
        data_err_idx    <= loc.data_idx;
        check_err_valid <= loc.chk_hit;
        check_err_idx   <= loc.chk_idx;
        uncorrectable   <= loc.uncorr;
        corr_data       <= fix_d;
        corr_check      <= fix_c;
      end
    end
  end

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(corr_data) && $stable(syndrome) && $stable(corr_check)));
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $countones({data_err_valid, check_err_valid, uncorrectable}) <= 1);
  assert_clean_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && syndrome == '0) |->
      (!data_err_valid && !check_err_valid && !uncorrectable &&
       corr_data == $past(in_data) && corr_check == $past(in_check)));
  assert_data_flip_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && data_err_valid) |->
      ($countones(corr_data ^ $past(in_data)) == 1 && corr_check == $past(in_check)));
  assert_chk_weight_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && check_err_valid) |->
      ($countones(syndrome) == 1 && corr_data == $past(in_data) &&
       $countones(corr_check ^ $past(in_check)) == 1));
  assert_unc_weight_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && uncorrectable) |->
      ($countones(syndrome) > 1 && corr_data == $past(in_data) &&
       corr_check == $past(in_check)));
endmodule

// File: tb/secded64_codec_tb.sv
module secded64_codec_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_check = '0;
  logic        out_valid;
  logic [7:0]  enc_check;
  logic [7:0]  syndrome;
  logic        data_err_valid;
  logic [5:0]  data_err_idx;
  logic        check_err_valid;
  logic [2:0]  check_err_idx;
  logic        uncorrectable;
  logic [63:0] corr_data;
  logic [7:0]  corr_check;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mhi [8];
  logic [31:0] mlo [8];

  always #2 clk = ~clk;

  secded64_codec u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_check(in_check), .out_valid(out_valid), .enc_check(enc_check),
    .syndrome(syndrome), .data_err_valid(data_err_valid),
    .data_err_idx(data_err_idx), .check_err_valid(check_err_valid),
    .check_err_idx(check_err_idx), .uncorrectable(uncorrectable),
    .corr_data(corr_data), .corr_check(corr_check)
  );

  function automatic logic [7:0] model_ecc(input logic [63:0] d);
    logic [7:0] e;
    for (int k = 0; k < 8; k++)
      e[k] = ^(d[63:32] & mhi[k]) ^ ^(d[31:0] & mlo[k]);
    return e;
  endfunction

  function automatic logic [7:0] model_col(input int n);
    logic [7:0] c;
    for (int k = 0; k < 8; k++)
      c[k] = (n < 32) ? mlo[k][n] : mhi[k][n-32];
    return c;
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one word at a falling edge, then check it at the next falling edge.
  task automatic apply(input logic [63:0] d, input logic [7:0] c);
    logic [7:0]  e, s;
    int          dn, cn, w;
    logic [63:0] xd;
    logic [7:0]  xc;
    in_data  = d;
    in_check = c;
    in_valid = 1'b1;
    @(negedge clk);
    e  = model_ecc(d);
    s  = e ^ c;
    dn = -1;
    cn = -1;
    if (s != 0)
      for (int n = 63; n >= 0; n--) if (model_col(n) == s) dn = n;
    w = $countones(s);
    if (s != 0 && dn < 0 && w == 1)
      for (int k = 7; k >= 0; k--) if (s[k]) cn = k;
    xd = d;
    xc = c;
    if (dn >= 0) xd[dn] = ~xd[dn];
    if (cn >= 0) xc[cn] = ~xc[cn];
    cmp("R7", "out_valid", 64'(out_valid), 64'd1);
    cmp("R1", "enc_check", 64'(enc_check), 64'(e));
    cmp("R2", "syndrome", 64'(syndrome), 64'(s));
    cmp("R4", "data_err_valid", 64'(data_err_valid), 64'(dn >= 0));
    if (dn >= 0) cmp("R4", "data_err_idx", 64'(data_err_idx), 64'(dn));
    cmp("R5", "check_err_valid", 64'(check_err_valid), 64'(cn >= 0));
    if (cn >= 0) cmp("R5", "check_err_idx", 64'(check_err_idx), 64'(cn));
    cmp("R6", "uncorrectable", 64'(uncorrectable), 64'(s != 0 && dn < 0 && w > 1));
    cmp(s == 0 ? "R3" : "R4", "corr_data", corr_data, xd);
    cmp(s == 0 ? "R3" : "R5", "corr_check", 64'(corr_check), 64'(xc));
    cmp("R9", "flag_count",
        64'($countones({data_err_valid, check_err_valid, uncorrectable})), 64'(w == 0 ? 0 : 1));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] base [4];
    logic [63:0] hd;
    logic [7:0]  hc, hs;
    mhi[0] = 32'hf00fe11e; mlo[0] = 32'hc33c0ff7;
    mhi[1] = 32'h00ff00ff; mlo[1] = 32'h00fff0ff;
    mhi[2] = 32'h0f0f0f0f; mlo[2] = 32'h0f0fff00;
    mhi[3] = 32'h11113333; mlo[3] = 32'h7777000f;
    mhi[4] = 32'h22224444; mlo[4] = 32'h8888222f;
    mhi[5] = 32'h44448888; mlo[5] = 32'hffff4441;
    mhi[6] = 32'h8888ffff; mlo[6] = 32'h11118882;
    mhi[7] = 32'hffff1111; mlo[7] = 32'h22221114;
    base[0] = 64'h0; base[1] = 64'hffff_ffff_ffff_ffff;
    base[2] = 64'hdead_beef_0123_4567; base[3] = 64'h5a5a_a5a5_3c3c_c3c3;

    repeat (3) @(negedge clk);
    cmp("R7", "reset out_valid", 64'(out_valid), 64'd0);
    cmp("R3", "reset corr_data", corr_data, 64'd0);
    cmp("R9", "reset flags", 64'({data_err_valid, check_err_valid, uncorrectable}), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R3: clean codewords
    for (int i = 0; i < 4; i++) apply(base[i], model_ecc(base[i]));
    // R4: every single data bit flip
    for (int n = 0; n < 64; n++) apply(base[2] ^ (64'd1 << n), model_ecc(base[2]));
    // R5: every single check bit flip
    for (int k = 0; k < 8; k++) apply(base[3], model_ecc(base[3]) ^ (8'd1 << k));
    // R6: adjacent double data flips
    for (int n = 0; n < 63; n++) apply(base[1] ^ (64'd3 << n), model_ecc(base[1]));
    // R2..R6: all 256 syndromes over two words
    for (int s = 0; s < 256; s++) apply(base[0], model_ecc(base[0]) ^ 8'(s));
    for (int s = 0; s < 256; s++) apply(base[2], model_ecc(base[2]) ^ 8'(s));

    // R8: inputs change while in_valid is low, results hold
    apply(base[2] ^ 64'd1, model_ecc(base[2]) ^ 8'h81);
    hd = corr_data; hc = corr_check; hs = syndrome;
    in_valid = 1'b0;
    in_data  = base[3];
    in_check = 8'h00;
    @(negedge clk);
    cmp("R7", "out_valid low", 64'(out_valid), 64'd0);
    @(negedge clk);
    cmp("R8", "held corr_data", corr_data, hd);
    cmp("R8", "held corr_check", 64'(corr_check), 64'(hc));
    cmp("R8", "held syndrome", 64'(syndrome), 64'(hs));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule